// File: doc/BRIEF.md
# Bus-mapped GPIO and interrupt expander

This block sits on a host's simple synchronous memory bus and extends it with a bank of general-purpose pins and a small interrupt collector. Every pin has a direction chosen when the block is built: output pins are driven from latches that the host writes a whole register at a time, while input pins are brought through a two-stage synchroniser and can be read back. The pins are grouped into registers 8 or 16 bits wide, and the registers are placed on the bus at a 2-byte or 4-byte stride.

A separate status register collects up to 16 interrupt sources. A rising edge on any source sets its pending bit, and every pending bit feeds one aggregated interrupt output toward the host. The chip has no mask, so the host filters unwanted sources itself. The host reads the status register to learn which sources fired. It clears all of them at once by writing a fixed acknowledge word to that same register: all ones by default, all zeros when the inverted-acknowledge parameter is set. After each acknowledge the interrupt output drops for at least one cycle, so a host that watches for edges always sees a fresh rising edge when work remains.

Top module: `pinexp_top`

## Requirements
- R1: Register index k answers at byte address k*STRIDE (default STRIDE 4). An address that is not a multiple of STRIDE is unmapped.
- R2: Pin n belongs to register GROUP_BASE + n/REG_W at bit n mod REG_W. The defaults are 24 pins, REG_W 8, GROUP_BASE 0 and PIN_DIR 0x0F00FF, where 1 means output.
- R3: A write to a pin register sets all of that register's output bits to the low REG_W bits of the written word in the same clock edge, and pin_out shows the new value from that edge on. Data bits above REG_W are ignored.
- R4: A pin-register read returns the latched value for output bits. For input bits it returns the pin level, which appears in read data after two clock edges. Reads are combinational from the address.
- R5: A write has no effect on input-only bits, and pin_out is always 0 at input positions.
- R6: During and after reset, output pins hold PIN_INIT (default 0x0500A5) masked by PIN_DIR, no source is pending and irq_out is 0.
- R7: A rising edge on irq_src[i] sets pending bit i of the status register (default index 4, address 0x10), readable on bits [NUM_SRC-1:0] three clock edges after the edge. Upper bits read 0. Holding a source high or lowering it sets nothing.
- R8: Writing the acknowledge word (0xFFFF, or 0x0000 when ACK_INVERT is 1) to the status register clears every pending bit. Any other value written there has no effect.
- R9: A source edge that is captured in the same cycle as an acknowledge stays pending.
- R10: irq_out is high one edge after any bit is pending. It is low for the cycle after every acknowledge and rises again if a bit is still pending.
- R11: Unmapped addresses read as 0, and writes to them change no state.
- R12: There is no per-source mask: each of the NUM_SRC sources on its own raises irq_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, zero-extended |
| pin_in | input | NUM_PINS | External pin levels (used at input positions) |
| pin_out | output | NUM_PINS | Output pin drive (0 at input positions) |
| irq_src | input | NUM_SRC | Interrupt source lines |
| irq_out | output | 1 | Aggregated interrupt toward the host |

## Verification
The hardest case is an acknowledge that lands in the same cycle as a new source edge. A design where clearing beats setting would lose that interrupt. A design whose interrupt output simply follows the OR of the pending bits would stay high through the acknowledge, so the host would never see the new edge. The bench also writes to input-only bits, to misaligned addresses and to gaps in the map, and writes non-matching words to the status register, checking that nothing moves. It checks the two-edge input latency and the three-edge capture latency cycle by cycle, and runs a second copy with the inverted acknowledge word to confirm that the polarity is not swapped.

// File: rtl/pinexp_pkg.sv
package pinexp_pkg;

    localparam int BUS_DW = 16;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_PIN,
        ACC_IRQ
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e  kind;
        logic [7:0] grp;
    } acc_t;

    function automatic logic [BUS_DW-1:0] ack_word(input bit inverted);
        return inverted ? {BUS_DW{1'b0}} : {BUS_DW{1'b1}};
    endfunction

    function automatic int regs_for(input int pins, input int width);
        return (pins + width - 1) / width;
    endfunction

endpackage

// File: rtl/pinexp_decode.sv
module pinexp_decode
    import pinexp_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int STRIDE     = 4,
    parameter int GROUP_BASE = 0,
    parameter int NREGS      = 3,
    parameter int IRQ_IDX    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_t              acc
);
    localparam int SH = $clog2(STRIDE);

    logic [ADDR_W-1:0] idx_w;
    logic              aligned;

    assign idx_w   = addr >> SH;
    assign aligned = (addr[SH-1:0] == '0);

    always_comb begin
        int ix;
        ix       = int'(idx_w);
        acc.kind = ACC_NONE;
        acc.grp  = '0;
        if (aligned) begin
            if (ix == IRQ_IDX) begin
                acc.kind = ACC_IRQ;
            end else if (ix >= GROUP_BASE && ix < GROUP_BASE + NREGS) begin
                acc.kind = ACC_PIN;
                acc.grp  = 8'(ix - GROUP_BASE);
            end
        end
    end

endmodule

// File: rtl/pinexp_pins.sv
module pinexp_pins
    import pinexp_pkg::*;
#(
    parameter int                 NUM_PINS = 24,
    parameter int                 REG_W    = 8,
    parameter int                 NREGS    = 3,
    parameter logic [NUM_PINS-1:0] PIN_DIR  = '0,
    parameter logic [NUM_PINS-1:0] PIN_INIT = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [7:0]          grp,
    input  logic [BUS_DW-1:0]   wdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [BUS_DW-1:0]   rd_word
);
    localparam int TOT = NREGS * REG_W;

    logic [NUM_PINS-1:0] out_q;
    logic [NUM_PINS-1:0] sync1_q, sync2_q;
    logic [TOT-1:0]      view;
    logic [TOT-1:0]      sel_full;
    logic [TOT-1:0]      wvec_full;
    logic [NUM_PINS-1:0] wmask;
    logic [REG_W-1:0]    words [NREGS];

    assign wvec_full = {NREGS{wdata[REG_W-1:0]}};
    assign view      = TOT'((out_q & PIN_DIR) | (sync2_q & ~PIN_DIR));

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        assign sel_full[r*REG_W +: REG_W] = {REG_W{wr && (grp == 8'(r))}};
        assign words[r]                   = view[r*REG_W +: REG_W];
    end

    assign wmask = NUM_PINS'(sel_full) & PIN_DIR;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= PIN_INIT & PIN_DIR;
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            out_q   <= (out_q & ~wmask) | (NUM_PINS'(wvec_full) & wmask);
            sync1_q <= pin_in;
            sync2_q <= sync1_q;
        end
    end

    always_comb begin
        rd_word = '0;
        for (int r = 0; r < NREGS; r++) begin
            if (grp == 8'(r)) rd_word = BUS_DW'(words[r]);
        end
    end

    assign pin_out = out_q;

    // R3: latches move only on a write strobe
    p_out_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(pin_out));

    // R5: input positions are never driven
    p_input_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        wr |=> ((pin_out & ~PIN_DIR) == '0));

endmodule

// File: rtl/pinexp_irq.sv
module pinexp_irq
    import pinexp_pkg::*;
#(
    parameter int NUM_SRC    = 8,
    parameter bit ACK_INVERT = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src,
    input  logic               wr_irq,
    input  logic [BUS_DW-1:0]  wdata,
    output logic [NUM_SRC-1:0] pending,
    output logic               irq_out
);
    logic [NUM_SRC-1:0] s1_q, s2_q, prev_q, rise, pend_q;
    logic               ack, irq_q;

    assign ack  = wr_irq && (wdata == ack_word(ACK_INVERT));
    assign rise = s2_q & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= '0;
            s2_q   <= '0;
            prev_q <= '0;
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            s1_q   <= src;
            s2_q   <= s1_q;
            prev_q <= s2_q;
            pend_q <= (ack ? '0 : pend_q) | rise;
            irq_q  <= ack ? 1'b0 : (|pend_q);
        end
    end

    assign pending = pend_q;
    assign irq_out = irq_q;

    // R10: every acknowledge gives a low cycle on the output
    p_ack_drops_irq_r10: assert property (@(posedge clk) disable iff (rst)
        ack |=> !irq_out);

    // R7 / R9: a captured edge is pending on the next cycle, ack or not
    p_edge_captured_r9: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((pending & $past(rise)) == $past(rise)));

    // R8: an acknowledge with no new edge empties the register
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (ack && rise == '0) |=> (pending == '0));

    // R7: no edge and no ack leaves the pending bits alone
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
        (!ack && rise == '0) |=> $stable(pending));

    // R12: the output is only high with something pending behind it
    p_irq_has_cause_r12: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> $past(|pending));

endmodule

// File: rtl/pinexp_top.sv
module pinexp_top
    import pinexp_pkg::*;
#(
    parameter int                  REG_W      = 8,
    parameter int                  STRIDE     = 4,
    parameter int                  ADDR_W     = 8,
    parameter int                  NUM_PINS   = 24,
    parameter int                  GROUP_BASE = 0,
    parameter int                  IRQ_IDX    = 4,
    parameter int                  NUM_SRC    = 8,
    parameter bit                  ACK_INVERT = 1'b0,
    parameter logic [NUM_PINS-1:0] PIN_DIR    = 24'h0F00FF,
    parameter logic [NUM_PINS-1:0] PIN_INIT   = 24'h0500A5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_DW-1:0]   bus_wdata,
    output logic [BUS_DW-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    input  logic [NUM_SRC-1:0]  irq_src,
    output logic                irq_out
);
    localparam int NREGS = regs_for(NUM_PINS, REG_W);

    acc_t               acc;
    logic [BUS_DW-1:0]  pin_rd;
    logic [NUM_SRC-1:0] pending;
    logic               wr_pin, wr_irq;

    pinexp_decode #(
        .ADDR_W(ADDR_W), .STRIDE(STRIDE), .GROUP_BASE(GROUP_BASE),
        .NREGS(NREGS), .IRQ_IDX(IRQ_IDX)
    ) u_decode (
        .addr(bus_addr),
        .acc (acc)
    );

    assign wr_pin = bus_wr && (acc.kind == ACC_PIN);
    assign wr_irq = bus_wr && (acc.kind == ACC_IRQ);

    pinexp_pins #(
        .NUM_PINS(NUM_PINS), .REG_W(REG_W), .NREGS(NREGS),
        .PIN_DIR(PIN_DIR), .PIN_INIT(PIN_INIT)
    ) u_pins (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_pin),
        .grp    (acc.grp),
        .wdata  (bus_wdata),
        .pin_in (pin_in),
        .pin_out(pin_out),
        .rd_word(pin_rd)
    );

    pinexp_irq #(
        .NUM_SRC(NUM_SRC), .ACK_INVERT(ACK_INVERT)
    ) u_irq (
        .clk    (clk),
        .rst    (rst),
        .src    (irq_src),
        .wr_irq (wr_irq),
        .wdata  (bus_wdata),
        .pending(pending),
        .irq_out(irq_out)
    );

    always_comb begin
        unique case (acc.kind)
            ACC_PIN: bus_rdata = pin_rd;
            ACC_IRQ: bus_rdata = BUS_DW'(pending);
            default: bus_rdata = '0;
        endcase
    end

    // R11: a write outside the map leaves the pins alone
    p_unmapped_write_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && acc.kind == ACC_NONE) |=> $stable(pin_out));

    // R11: a write outside the map leaves the pending bits alone
    p_unmapped_irq_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && acc.kind == ACC_NONE && irq_src == '0 && $past(irq_src) == '0)
        |=> (pending & ~$past(pending)) == '0 || $past(rst));

endmodule

// File: tb/test_pinexp_top.sv
`timescale 1ns/1ps
module test_pinexp_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata, rdata_b;
    logic [23:0] pin_in, pin_out, pin_out_b;
    logic [7:0]  irq_src, src_b;
    logic        irq_out, irq_b;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pinexp_top i_pinexp_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .irq_src(irq_src), .irq_out(irq_out)
    );

    pinexp_top #(.ACK_INVERT(1'b1)) i_pinexp_top_inv (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .pin_in(pin_in),
        .pin_out(pin_out_b), .irq_src(src_b), .irq_out(irq_b)
    );

    typedef struct packed {
        logic        do_wr;
        logic [7:0]  wr_addr;
        logic [15:0] wr_data;
        logic [7:0]  rd_addr;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 16'h0000, 8'h00, 16'h00A5, 8'd6},  // R6 initial outputs
        '{1'b0, 8'h00, 16'h0000, 8'h04, 16'h005A, 8'd4},  // R4 input register
        '{1'b0, 8'h00, 16'h0000, 8'h08, 16'h00C5, 8'd2},  // R2 mixed register
        '{1'b1, 8'h00, 16'h003C, 8'h00, 16'h003C, 8'd3},  // R3 whole-register write
        '{1'b1, 8'h04, 16'h00FF, 8'h04, 16'h005A, 8'd5},  // R5 inputs ignore writes
        '{1'b1, 8'h08, 16'h00FA, 8'h08, 16'h00CA, 8'd5},  // R5 only out nibble moves
        '{1'b0, 8'h00, 16'h0000, 8'h0C, 16'h0000, 8'd11}, // R11 gap reads zero
        '{1'b1, 8'h0C, 16'h00FF, 8'h00, 16'h003C, 8'd11}, // R11 gap write no effect
        '{1'b0, 8'h00, 16'h0000, 8'h02, 16'h0000, 8'd1},  // R1 misaligned read
        '{1'b1, 8'h01, 16'h0000, 8'h00, 16'h003C, 8'd1},  // R1 misaligned write
        '{1'b0, 8'h00, 16'h0000, 8'h10, 16'h0000, 8'd7},  // R7 nothing pending
        '{1'b1, 8'h40, 16'hFFFF, 8'h08, 16'h00CA, 8'd11}, // R11 far address
        '{1'b1, 8'h00, 16'h1234, 8'h00, 16'h0034, 8'd3}   // R3 upper bits dropped
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 16'h0000;
        pin_in = 24'hC35AFF; irq_src = 8'h00; src_b = 8'h00;
        settle(4);
        chk("R6 pin_out in reset", 32'(pin_out), 32'h0500A5);
        rst = 1'b0;
        settle(3);
        chk("R6 pin_out after reset", 32'(pin_out), 32'h0500A5);
        chk("R6 irq_out after reset", 32'(irq_out), 32'h0);

        for (int v = 0; v < NV; v++) begin
            if (VECS[v].do_wr) bus_write(VECS[v].wr_addr, VECS[v].wr_data);
            @(negedge clk);
            bus_addr = VECS[v].rd_addr;
            #1;
            chk($sformatf("R%0d vector %0d", VECS[v].req, v),
                32'(bus_rdata), 32'(VECS[v].exp));
        end
        chk("R3 R5 pin_out after writes", 32'(pin_out), 32'h0A0034);

        // R4: two-edge input latency
        @(negedge clk);
        bus_addr = 8'h04; pin_in[15:8] = 8'h81;
        @(negedge clk);
        chk("R4 one edge after change", 32'(bus_rdata), 32'h5A);
        @(negedge clk);
        chk("R4 two edges after change", 32'(bus_rdata), 32'h81);

        // R7: edge capture latency on source 2
        bus_addr = 8'h10; irq_src[2] = 1'b1;
        settle(2);
        chk("R7 not pending after two edges", 32'(bus_rdata), 32'h0);
        @(negedge clk);
        chk("R7 pending after three edges", 32'(bus_rdata), 32'h04);
        chk("R10 irq_out not yet high", 32'(irq_out), 32'h0);
        @(negedge clk);
        chk("R10 irq_out high", 32'(irq_out), 32'h1);
        irq_src[2] = 1'b0;
        settle(4);
        chk("R7 falling edge sets nothing", 32'(bus_rdata), 32'h04);

        // R12: highest source also reaches the status register
        irq_src[7] = 1'b1;
        settle(4);
        chk("R12 source 7 pending", 32'(bus_rdata), 32'h84);

        // R8: wrong word leaves everything pending
        bus_write(8'h10, 16'h1234);
        bus_write(8'h10, 16'h0000);
        chk("R8 non-ack words ignored", 32'(bus_rdata), 32'h84);
        chk("R8 irq_out still high", 32'(irq_out), 32'h1);

        // R9: ack coinciding with a new edge on source 5
        @(negedge clk);
        irq_src[5] = 1'b1;
        settle(2);
        bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 16'hFFFF;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R9 coinciding edge kept", 32'(bus_rdata), 32'h20);
        chk("R10 irq_out low after ack", 32'(irq_out), 32'h0);
        @(negedge clk);
        chk("R10 irq_out rises again", 32'(irq_out), 32'h1);

        // R8: plain ack, held source does not re-arm
        bus_write(8'h10, 16'hFFFF);
        chk("R8 ack clears all", 32'(bus_rdata), 32'h0);
        settle(3);
        chk("R7 held level sets nothing", 32'(bus_rdata), 32'h0);
        chk("R10 irq_out stays low", 32'(irq_out), 32'h0);

        // R8: inverted acknowledge copy
        src_b[0] = 1'b1;
        settle(4);
        chk("R8 inv copy pending", 32'(rdata_b), 32'h01);
        bus_write(8'h10, 16'hFFFF);
        chk("R8 inv copy ignores all-ones", 32'(rdata_b), 32'h01);
        bus_write(8'h10, 16'h0000);
        chk("R8 inv copy clears on zeros", 32'(rdata_b), 32'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule